// File: doc/BRIEF.md
# Boot-Mode Latch and Code-Window Remapper

This block decides which physical memory answers in the low code window that starts at address zero. Two external boot-select inputs are captured a fixed number of clock edges after reset is released. They are captured again after the device comes back from standby. Each capture loads a two-bit remap register. Once the boot value is valid, software may overwrite that register. The block then decodes any 32-bit address into a target code and an offset within that target.

A memory placed in the code window can still be reached at its own native address. When the external memory bank is placed in the window, only its first two regions can be reached through the bank. Its configuration registers are hidden until software selects another source. A "pin free" output tells the I/O logic that the shared boot input may be used for other functions.

Top module: `bootmap_top`

## Requirements
- R1: The boot inputs are captured on the 4th rising clock edge after reset is released, as `boot_mode_o` = {`boot_b_i`, `boot_a_i`}. `boot_valid_o` is 0 before that edge and 1 from it onward.
- R2: A clock edge on which `standby_exit_i` is 1 clears `boot_valid_o`. The inputs are captured again on the 4th rising edge after that edge, and the new value replaces the old one.
- R3: `pin_free_o` is 1 exactly while a captured boot value is valid. It is 0 in reset and during a re-capture delay.
- R4: Each capture loads `remap_o` from the captured pins: `boot_a_i`=0 gives 00 (flash), {b,a}=01 gives 01 (system memory), {b,a}=11 gives 11 (SRAM1). `remap_o` is 00 in reset.
- R5: A write (`remap_wr_i`=1) loads `remap_wdata_i` into `remap_o` on the next edge only while `boot_valid_o` is 1; otherwise it is ignored. Codes: 00 flash, 01 system memory, 10 external bank, 11 SRAM1.
- R6: Native decode, with `tgt_o` codes 1 to 4 and `offset_o` = address minus base: flash (1) 0x0800_0000 to 0x080F_FFFF, system memory (2) 0x1FFF_0000 to 0x1FFF_77FF, SRAM1 (3) 0x2000_0000 to 0x2001_BFFF, SRAM2 (4) 0x2001_C000 to 0x2001_FFFF.
- R7: Reserved ranges 0x0400_0000 to 0x07FF_FFFF and 0x0810_0000 to 0x0FFF_FFFF, and any other undecoded address, give `tgt_o`=0 (none) with offset 0 and `out_of_range_o`=0.
- R8: While valid, an address below 0x0400_0000 decodes to the target chosen by `remap_o`, with offset equal to the address. If the address is at or beyond the selected memory size (flash 1 MiB, system memory 30 KiB, SRAM1 112 KiB, external 64 MiB), the result is `tgt_o`=7 (error), offset 0 and `out_of_range_o`=1.
- R9: While `boot_valid_o` is 0, any address below 0x0400_0000 decodes to `tgt_o`=7 with `out_of_range_o`=0.
- R10: The external bank spans 0x6000_0000 to 0x67FF_FFFF (`tgt_o`=5, four 32 MiB regions) and its configuration block spans 0xA000_0000 to 0xA000_0FFF (`tgt_o`=6). While valid with `remap_o`=10, `ext_regs_blocked_o` is 1. In that state, the configuration block and regions 2 to 3 (from 0x6400_0000) decode to `tgt_o`=7 with offset 0.
- R11: A memory aliased into the code window still decodes at its native address with its normal target and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_a_i | input | 1 | Dedicated boot-select input |
| boot_b_i | input | 1 | Boot-select input shared with general I/O |
| standby_exit_i | input | 1 | High for a cycle when the device leaves standby |
| remap_wr_i | input | 1 | Remap register write strobe |
| remap_wdata_i | input | 2 | Remap register write value |
| addr_i | input | 32 | Address to decode |
| boot_mode_o | output | 2 | Captured {b, a} boot value |
| boot_valid_o | output | 1 | Captured boot value is valid |
| pin_free_o | output | 1 | Shared boot input released |
| remap_o | output | 2 | Current remap selection |
| tgt_o | output | 3 | Decoded target code |
| offset_o | output | 32 | Offset inside the target |
| out_of_range_o | output | 1 | Alias access beyond the selected memory |
| ext_regs_blocked_o | output | 1 | External bank configuration hidden |

## Verification
Suppose the edge counter is off by one, or a standby exit fails to restart it. Then `boot_valid_o` and `pin_free_o` move one edge early or late, and `boot_mode_o` picks up the pins one edge away from the intended one. The bench changes the pins just before the sampling edge, so both faults show on the port at that edge. A wrong remap state is visible directly on `remap_o`. It also shows combinationally in the very next address decoded: wrong `tgt_o` or offset in the code window, or a wrong lock on the external configuration block. Random addresses cover every region and its boundary after each random remap write.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_FLASH  = 3'd1,
    TGT_SYSMEM = 3'd2,
    TGT_SRAM1  = 3'd3,
    TGT_SRAM2  = 3'd4,
    TGT_EXTMEM = 3'd5,
    TGT_EXTCFG = 3'd6,
    TGT_ERROR  = 3'd7
  } tgt_e;

  typedef enum logic [1:0] {
    REMAP_FLASH  = 2'b00,
    REMAP_SYSMEM = 2'b01,
    REMAP_EXT    = 2'b10,
    REMAP_SRAM1  = 2'b11
  } remap_e;

  // Boot pins {b, a} to the remap source loaded at each capture.
  function automatic remap_e boot_to_remap(input logic [1:0] pins);
    if (!pins[0])     return REMAP_FLASH;
    else if (pins[1]) return REMAP_SRAM1;
    else              return REMAP_SYSMEM;
  endfunction

  // Address lies in [base, base + size).
  function automatic logic span_hit(input logic [31:0] addr,
                                    input logic [31:0] base,
                                    input logic [31:0] size);
    return (addr >= base) && ((addr - base) < size);
  endfunction

  function automatic tgt_e alias_target(input remap_e sel);
    case (sel)
      REMAP_FLASH:  return TGT_FLASH;
      REMAP_SYSMEM: return TGT_SYSMEM;
      REMAP_EXT:    return TGT_EXTMEM;
      default:      return TGT_SRAM1;
    endcase
  endfunction

endpackage

// File: rtl/bootmap_sampler.sv
module bootmap_sampler #(
  parameter int SAMPLE_EDGE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_a_i,
  input  logic       boot_b_i,
  input  logic       standby_exit_i,
  output logic [1:0] boot_mode_o,
  output logic       valid_o,
  output logic       sample_pulse_o
);
  localparam int CNT_W = (SAMPLE_EDGE < 2) ? 1 : $clog2(SAMPLE_EDGE);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SAMPLE_EDGE - 1);

  logic [CNT_W-1:0] edge_cnt_q;

  // The edge on which the pins are taken; a standby exit on that edge wins.
  assign sample_pulse_o = !valid_o && !standby_exit_i && (edge_cnt_q == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt_q  <= '0;
      valid_o     <= 1'b0;
      boot_mode_o <= 2'b00;
    end else if (standby_exit_i) begin
      edge_cnt_q <= '0;
      valid_o    <= 1'b0;
    end else if (sample_pulse_o) begin
      edge_cnt_q  <= '0;
      valid_o     <= 1'b1;
      boot_mode_o <= {boot_b_i, boot_a_i};
    end else if (!valid_o) begin
      edge_cnt_q <= edge_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bootmap_remap_reg.sv
module bootmap_remap_reg
  import bootmap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_boot_i,
  input  logic [1:0] boot_pins_i,
  input  logic       wr_en_i,
  input  logic       wr_allowed_i,
  input  logic [1:0] wr_data_i,
  output remap_e     remap_q
);
  logic sw_write;
  assign sw_write = wr_en_i && wr_allowed_i;

  // Capture has priority over a software write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          remap_q <= REMAP_FLASH;
    else if (load_boot_i) remap_q <= boot_to_remap(boot_pins_i);
    else if (sw_write)    remap_q <= remap_e'(wr_data_i);
  end
endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
  import bootmap_pkg::*;
#(
  parameter logic [31:0] WINDOW_BYTES     = 32'h0400_0000,
  parameter logic [31:0] FLASH_BASE       = 32'h0800_0000,
  parameter logic [31:0] FLASH_BYTES      = 32'h0010_0000,
  parameter logic [31:0] SYSMEM_BASE      = 32'h1FFF_0000,
  parameter logic [31:0] SYSMEM_BYTES     = 32'h0000_7800,
  parameter logic [31:0] SRAM1_BASE       = 32'h2000_0000,
  parameter logic [31:0] SRAM1_BYTES      = 32'h0001_C000,
  parameter logic [31:0] SRAM2_BASE       = 32'h2001_C000,
  parameter logic [31:0] SRAM2_BYTES      = 32'h0000_4000,
  parameter logic [31:0] EXT_BASE         = 32'h6000_0000,
  parameter logic [31:0] EXT_REGION_BYTES = 32'h0200_0000,
  parameter int          EXT_REGIONS      = 4,
  parameter int          EXT_OPEN_REGIONS = 2,
  parameter logic [31:0] EXTCFG_BASE      = 32'hA000_0000,
  parameter logic [31:0] EXTCFG_BYTES     = 32'h0000_1000
) (
  input  logic [31:0] addr_i,
  input  logic        boot_valid_i,
  input  remap_e      remap_i,
  output tgt_e        tgt_o,
  output logic [31:0] offset_o,
  output logic        out_of_range_o,
  output logic        ext_locked_o
);
  localparam int NAT_N = 4;
  localparam logic [31:0] EXT_SPAN  = 32'(EXT_REGION_BYTES * EXT_REGIONS);
  localparam logic [31:0] EXT_OPEN  = 32'(EXT_REGION_BYTES * EXT_OPEN_REGIONS);
  localparam logic [31:0] NAT_BASE [NAT_N] = '{FLASH_BASE, SYSMEM_BASE, SRAM1_BASE, SRAM2_BASE};
  localparam logic [31:0] NAT_SIZE [NAT_N] = '{FLASH_BYTES, SYSMEM_BYTES, SRAM1_BYTES, SRAM2_BYTES};
  localparam tgt_e        NAT_TGT  [NAT_N] = '{TGT_FLASH, TGT_SYSMEM, TGT_SRAM1, TGT_SRAM2};

  // Size of the memory seen through the code window for each remap code.
  function automatic logic [31:0] alias_bytes(input remap_e sel);
    case (sel)
      REMAP_FLASH:  return FLASH_BYTES;
      REMAP_SYSMEM: return SYSMEM_BYTES;
      REMAP_EXT:    return EXT_OPEN;
      default:      return SRAM1_BYTES;
    endcase
  endfunction

  logic [NAT_N-1:0] nat_hit;
  logic [31:0]      nat_off [NAT_N];
  logic             in_window, ext_hit, cfg_hit, alias_fits;
  logic [31:0]      ext_off, cfg_off;

  for (genvar g = 0; g < NAT_N; g++) begin : g_native
    assign nat_hit[g] = span_hit(addr_i, NAT_BASE[g], NAT_SIZE[g]);
    assign nat_off[g] = addr_i - NAT_BASE[g];
  end

  assign in_window    = addr_i < WINDOW_BYTES;
  assign alias_fits   = addr_i < alias_bytes(remap_i);
  assign ext_hit      = span_hit(addr_i, EXT_BASE, EXT_SPAN);
  assign ext_off      = addr_i - EXT_BASE;
  assign cfg_hit      = span_hit(addr_i, EXTCFG_BASE, EXTCFG_BYTES);
  assign cfg_off      = addr_i - EXTCFG_BASE;
  assign ext_locked_o = boot_valid_i && (remap_i == REMAP_EXT);

  always_comb begin
    tgt_o          = TGT_NONE;
    offset_o       = '0;
    out_of_range_o = 1'b0;
    if (in_window) begin
      if (!boot_valid_i) begin
        tgt_o = TGT_ERROR;
      end else if (alias_fits) begin
        tgt_o    = alias_target(remap_i);
        offset_o = addr_i;
      end else begin
        tgt_o          = TGT_ERROR;
        out_of_range_o = 1'b1;
      end
    end else if (|nat_hit) begin
      for (int i = NAT_N - 1; i >= 0; i--) begin
        if (nat_hit[i]) begin
          tgt_o    = NAT_TGT[i];
          offset_o = nat_off[i];
        end
      end
    end else if (ext_hit) begin
      if (ext_locked_o && (ext_off >= EXT_OPEN)) begin
        tgt_o = TGT_ERROR;
      end else begin
        tgt_o    = TGT_EXTMEM;
        offset_o = ext_off;
      end
    end else if (cfg_hit) begin
      if (ext_locked_o) begin
        tgt_o = TGT_ERROR;
      end else begin
        tgt_o    = TGT_EXTCFG;
        offset_o = cfg_off;
      end
    end
  end
endmodule

// File: rtl/bootmap_top.sv
module bootmap_top
  import bootmap_pkg::*;
#(
  parameter int          SAMPLE_EDGE      = 4,
  parameter logic [31:0] WINDOW_BYTES     = 32'h0400_0000,
  parameter logic [31:0] FLASH_BASE       = 32'h0800_0000,
  parameter logic [31:0] FLASH_BYTES      = 32'h0010_0000,
  parameter logic [31:0] SYSMEM_BASE      = 32'h1FFF_0000,
  parameter logic [31:0] SYSMEM_BYTES     = 32'h0000_7800,
  parameter logic [31:0] SRAM1_BASE       = 32'h2000_0000,
  parameter logic [31:0] SRAM1_BYTES      = 32'h0001_C000,
  parameter logic [31:0] SRAM2_BASE       = 32'h2001_C000,
  parameter logic [31:0] SRAM2_BYTES      = 32'h0000_4000,
  parameter logic [31:0] EXT_BASE         = 32'h6000_0000,
  parameter logic [31:0] EXT_REGION_BYTES = 32'h0200_0000,
  parameter int          EXT_REGIONS      = 4,
  parameter int          EXT_OPEN_REGIONS = 2,
  parameter logic [31:0] EXTCFG_BASE      = 32'hA000_0000,
  parameter logic [31:0] EXTCFG_BYTES     = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_a_i,
  input  logic        boot_b_i,
  input  logic        standby_exit_i,
  input  logic        remap_wr_i,
  input  logic [1:0]  remap_wdata_i,
  input  logic [31:0] addr_i,
  output logic [1:0]  boot_mode_o,
  output logic        boot_valid_o,
  output logic        pin_free_o,
  output logic [1:0]  remap_o,
  output logic [2:0]  tgt_o,
  output logic [31:0] offset_o,
  output logic        out_of_range_o,
  output logic        ext_regs_blocked_o
);
  logic   sample_pulse;
  logic   ext_locked;
  remap_e remap_q;
  tgt_e   tgt_w;

  bootmap_sampler #(.SAMPLE_EDGE(SAMPLE_EDGE)) u_sampler (
    .clk            (clk),
    .rst_n          (rst_n),
    .boot_a_i       (boot_a_i),
    .boot_b_i       (boot_b_i),
    .standby_exit_i (standby_exit_i),
    .boot_mode_o    (boot_mode_o),
    .valid_o        (boot_valid_o),
    .sample_pulse_o (sample_pulse)
  );

  bootmap_remap_reg u_remap (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_boot_i  (sample_pulse),
    .boot_pins_i  ({boot_b_i, boot_a_i}),
    .wr_en_i      (remap_wr_i),
    .wr_allowed_i (boot_valid_o),
    .wr_data_i    (remap_wdata_i),
    .remap_q      (remap_q)
  );

  bootmap_decoder #(
    .WINDOW_BYTES     (WINDOW_BYTES),
    .FLASH_BASE       (FLASH_BASE),
    .FLASH_BYTES      (FLASH_BYTES),
    .SYSMEM_BASE      (SYSMEM_BASE),
    .SYSMEM_BYTES     (SYSMEM_BYTES),
    .SRAM1_BASE       (SRAM1_BASE),
    .SRAM1_BYTES      (SRAM1_BYTES),
    .SRAM2_BASE       (SRAM2_BASE),
    .SRAM2_BYTES      (SRAM2_BYTES),
    .EXT_BASE         (EXT_BASE),
    .EXT_REGION_BYTES (EXT_REGION_BYTES),
    .EXT_REGIONS      (EXT_REGIONS),
    .EXT_OPEN_REGIONS (EXT_OPEN_REGIONS),
    .EXTCFG_BASE      (EXTCFG_BASE),
    .EXTCFG_BYTES     (EXTCFG_BYTES)
  ) u_decoder (
    .addr_i         (addr_i),
    .boot_valid_i   (boot_valid_o),
    .remap_i        (remap_q),
    .tgt_o          (tgt_w),
    .offset_o       (offset_o),
    .out_of_range_o (out_of_range_o),
    .ext_locked_o   (ext_locked)
  );

  assign pin_free_o         = boot_valid_o;
  assign remap_o            = remap_q;
  assign tgt_o              = tgt_w;
  assign ext_regs_blocked_o = ext_locked;
endmodule

// File: rtl/bootmap_checker.sv
module bootmap_checker
  import bootmap_pkg::*;
#(
  parameter logic [31:0] WINDOW_BYTES = 32'h0400_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        boot_a_i,
  input logic        boot_b_i,
  input logic        standby_exit_i,
  input logic        remap_wr_i,
  input logic [31:0] addr_i,
  input logic [1:0]  boot_mode_o,
  input logic        boot_valid_o,
  input logic        pin_free_o,
  input logic [1:0]  remap_o,
  input logic [2:0]  tgt_o,
  input logic        out_of_range_o,
  input logic        ext_regs_blocked_o,
  input logic        sample_pulse
);
  AST_SAMPLE_TAKES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse |=> (boot_mode_o == $past({boot_b_i, boot_a_i}))); // R1
  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_valid_o) |-> $past(sample_pulse)); // R1
  AST_STANDBY_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    standby_exit_i |=> !boot_valid_o); // R2
  AST_PIN_FREE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_free_o) |-> $past(sample_pulse)); // R3
  AST_REMAP_FROM_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse |=> (remap_o == boot_to_remap($past({boot_b_i, boot_a_i})))); // R4
  AST_EARLY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_wr_i && !boot_valid_o && !sample_pulse) |=> $stable(remap_o)); // R5
  AST_OOR_IS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range_o |-> (tgt_o == TGT_ERROR)); // R8
  AST_EARLY_WINDOW_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_valid_o && (addr_i < WINDOW_BYTES)) |-> (tgt_o == TGT_ERROR)); // R9
  AST_LOCK_HIDES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    ext_regs_blocked_o |-> (tgt_o != TGT_EXTCFG)); // R10
endmodule

bind bootmap_top bootmap_checker #(.WINDOW_BYTES(WINDOW_BYTES)) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .boot_a_i           (boot_a_i),
  .boot_b_i           (boot_b_i),
  .standby_exit_i     (standby_exit_i),
  .remap_wr_i         (remap_wr_i),
  .addr_i             (addr_i),
  .boot_mode_o        (boot_mode_o),
  .boot_valid_o       (boot_valid_o),
  .pin_free_o         (pin_free_o),
  .remap_o            (remap_o),
  .tgt_o              (tgt_o),
  .out_of_range_o     (out_of_range_o),
  .ext_regs_blocked_o (ext_regs_blocked_o),
  .sample_pulse       (sample_pulse)
);

// File: tb/bootmap_top_bench.sv
`timescale 1ns/1ps
module bootmap_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_a_i = 1'b0, boot_b_i = 1'b0, standby_exit_i = 1'b0;
  logic        remap_wr_i = 1'b0;
  logic [1:0]  remap_wdata_i = 2'b00;
  logic [31:0] addr_i = 32'h0;
  logic [1:0]  boot_mode_o, remap_o;
  logic        boot_valid_o, pin_free_o, out_of_range_o, ext_regs_blocked_o;
  logic [2:0]  tgt_o;
  logic [31:0] offset_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  bootmap_top u_bootmap_top (
    .clk(clk), .rst_n(rst_n), .boot_a_i(boot_a_i), .boot_b_i(boot_b_i),
    .standby_exit_i(standby_exit_i), .remap_wr_i(remap_wr_i),
    .remap_wdata_i(remap_wdata_i), .addr_i(addr_i), .boot_mode_o(boot_mode_o),
    .boot_valid_o(boot_valid_o), .pin_free_o(pin_free_o), .remap_o(remap_o),
    .tgt_o(tgt_o), .offset_o(offset_o), .out_of_range_o(out_of_range_o),
    .ext_regs_blocked_o(ext_regs_blocked_o));

  // Expected {oor, target, offset} stated from the requirements.
  function automatic logic [35:0] model_decode(input logic [31:0] a, input bit v,
                                               input logic [1:0] rm);
    logic [31:0] lim;
    logic [2:0]  t;
    bit          lock;
    lock = v && (rm == 2'b10);
    if (a <= 32'h03FF_FFFF) begin
      if (!v) return {1'b0, 3'd7, 32'h0};
      case (rm)
        2'b00:   begin lim = 32'h0010_0000; t = 3'd1; end
        2'b01:   begin lim = 32'h0000_7800; t = 3'd2; end
        2'b10:   begin lim = 32'h0400_0000; t = 3'd5; end
        default: begin lim = 32'h0001_C000; t = 3'd3; end
      endcase
      return (a < lim) ? {1'b0, t, a} : {1'b1, 3'd7, 32'h0};
    end
    if (a >= 32'h0800_0000 && a <= 32'h080F_FFFF) return {1'b0, 3'd1, a - 32'h0800_0000};
    if (a >= 32'h1FFF_0000 && a <= 32'h1FFF_77FF) return {1'b0, 3'd2, a - 32'h1FFF_0000};
    if (a >= 32'h2000_0000 && a <= 32'h2001_BFFF) return {1'b0, 3'd3, a - 32'h2000_0000};
    if (a >= 32'h2001_C000 && a <= 32'h2001_FFFF) return {1'b0, 3'd4, a - 32'h2001_C000};
    if (a >= 32'h6000_0000 && a <= 32'h67FF_FFFF) begin
      if (lock && a >= 32'h6400_0000) return {1'b0, 3'd7, 32'h0};
      return {1'b0, 3'd5, a - 32'h6000_0000};
    end
    if (a >= 32'hA000_0000 && a <= 32'hA000_0FFF)
      return lock ? {1'b0, 3'd7, 32'h0} : {1'b0, 3'd6, a - 32'hA000_0000};
    return {1'b0, 3'd0, 32'h0};
  endfunction

  function automatic logic [1:0] model_boot_remap(input logic b, input logic a);
    if (!a) return 2'b00;
    return b ? 2'b11 : 2'b01;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic dec_chk(input string tag, input logic [31:0] a, input bit v,
                         input logic [1:0] rm);
    addr_i = a;
    #1;
    chk(tag, {28'h0, out_of_range_o, tgt_o, offset_o}, {28'h0, model_decode(a, v, rm)});
  endtask

  task automatic sw_write(input logic [1:0] d);
    remap_wr_i = 1'b1;
    remap_wdata_i = d;
    tick();
    remap_wr_i = 1'b0;
  endtask

  function automatic logic [31:0] pick_addr();
    int k;
    k = int'($urandom % 10);
    case (k)
      0: return $urandom % 32'h0010_0400;
      1: return $urandom % 32'h0400_0000;
      2: return 32'h0800_0000 + ($urandom % 32'h0010_0100);
      3: return 32'h1FFE_FF00 + ($urandom % 32'h0000_7A00);
      4: return 32'h2000_0000 + ($urandom % 32'h0002_0100);
      5: return 32'h6000_0000 + ($urandom % 32'h0800_0100);
      6: return 32'hA000_0000 + ($urandom % 32'h0000_1100);
      7: return 32'h0400_0000 + ($urandom % 32'h0C00_0000);
      8: return $urandom % 32'h0001_E000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    logic [1:0] rm_model;
    seed_v = $urandom(32'h0000_5EED);
    boot_a_i = 1'b1; boot_b_i = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // Reset state
    chk("R1 reset valid", {63'h0, boot_valid_o}, 64'h0);
    chk("R3 reset pin_free", {63'h0, pin_free_o}, 64'h0);
    chk("R4 reset remap", {62'h0, remap_o}, 64'h0);
    dec_chk("R9 window before boot", 32'h0000_0004, 1'b0, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    tick();                                   // edge 1
    chk("R1 not valid edge1", {63'h0, boot_valid_o}, 64'h0);
    sw_write(2'b10);                          // edge 2, write ignored
    chk("R5 early write ignored", {62'h0, remap_o}, 64'h0);
    chk("R1 not valid edge2", {63'h0, boot_valid_o}, 64'h0);
    tick();                                   // edge 3
    chk("R1 not valid edge3", {63'h0, boot_valid_o}, 64'h0);
    chk("R3 pin busy edge3", {63'h0, pin_free_o}, 64'h0);
    boot_b_i = 1'b1;                          // change just before edge 4
    tick();                                   // edge 4
    chk("R1 valid edge4", {63'h0, boot_valid_o}, 64'h1);
    chk("R1 captured mode", {62'h0, boot_mode_o}, 64'h3);
    chk("R3 pin free", {63'h0, pin_free_o}, 64'h1);
    chk("R4 remap sram1", {62'h0, remap_o}, 64'h3);
    dec_chk("R8 sram1 alias base", 32'h0000_0000, 1'b1, 2'b11);
    dec_chk("R8 sram1 alias top", 32'h0001_BFFC, 1'b1, 2'b11);
    dec_chk("R8 sram1 alias past end", 32'h0001_C000, 1'b1, 2'b11);
    dec_chk("R11 sram1 native", 32'h2000_0004, 1'b1, 2'b11);
    sw_write(2'b00);
    chk("R5 write flash", {62'h0, remap_o}, 64'h0);
    dec_chk("R8 flash alias vector", 32'h0000_0004, 1'b1, 2'b00);
    dec_chk("R8 flash alias past end", 32'h0010_0000, 1'b1, 2'b00);
    dec_chk("R11 flash native", 32'h0800_0010, 1'b1, 2'b00);
    dec_chk("R6 flash top", 32'h080F_FFFF, 1'b1, 2'b00);
    dec_chk("R6 sysmem top", 32'h1FFF_77FF, 1'b1, 2'b00);
    dec_chk("R7 sysmem gap", 32'h1FFF_7800, 1'b1, 2'b00);
    dec_chk("R6 sram1 top", 32'h2001_BFFF, 1'b1, 2'b00);
    dec_chk("R6 sram2 base", 32'h2001_C000, 1'b1, 2'b00);
    dec_chk("R6 sram2 top", 32'h2001_FFFF, 1'b1, 2'b00);
    dec_chk("R7 reserved low", 32'h0400_0000, 1'b1, 2'b00);
    dec_chk("R7 reserved flash tail", 32'h0810_0000, 1'b1, 2'b00);
    dec_chk("R7 reserved end", 32'h0FFF_FFFC, 1'b1, 2'b00);
    dec_chk("R10 cfg open", 32'hA000_0010, 1'b1, 2'b00);
    dec_chk("R10 region2 open", 32'h6400_0000, 1'b1, 2'b00);
    chk("R10 not blocked", {63'h0, ext_regs_blocked_o}, 64'h0);
    sw_write(2'b10);
    chk("R10 blocked", {63'h0, ext_regs_blocked_o}, 64'h1);
    dec_chk("R10 ext alias top", 32'h03FF_FFFC, 1'b1, 2'b10);
    dec_chk("R10 cfg hidden", 32'hA000_0000, 1'b1, 2'b10);
    dec_chk("R10 region2 hidden", 32'h6400_0000, 1'b1, 2'b10);
    dec_chk("R11 ext native region0", 32'h6000_0100, 1'b1, 2'b10);

    // Standby exit with pins {b,a}=01
    boot_a_i = 1'b1; boot_b_i = 1'b0;
    standby_exit_i = 1'b1;
    tick();
    standby_exit_i = 1'b0;
    chk("R2 standby drops valid", {63'h0, boot_valid_o}, 64'h0);
    chk("R3 standby pin busy", {63'h0, pin_free_o}, 64'h0);
    dec_chk("R9 window during restart", 32'h0000_0000, 1'b0, 2'b10);
    for (int e = 1; e <= 3; e++) begin
      tick();
      chk("R2 waiting after standby", {63'h0, boot_valid_o}, 64'h0);
    end
    tick();
    chk("R2 resampled valid", {63'h0, boot_valid_o}, 64'h1);
    chk("R2 resampled mode", {62'h0, boot_mode_o}, 64'h1);
    chk("R4 remap sysmem", {62'h0, remap_o}, 64'h1);
    dec_chk("R8 sysmem alias top", 32'h0000_77FC, 1'b1, 2'b01);
    dec_chk("R8 sysmem alias past end", 32'h0000_7800, 1'b1, 2'b01);

    // Standby exit with pins {b,a}=10 -> flash
    boot_a_i = 1'b0; boot_b_i = 1'b1;
    standby_exit_i = 1'b1;
    tick();
    standby_exit_i = 1'b0;
    repeat (4) tick();
    chk("R2 second resample mode", {62'h0, boot_mode_o}, 64'h2);
    chk("R4 remap flash from a=0", {62'h0, remap_o}, 64'h0);

    // Random phase
    rm_model = 2'b00;
    for (int it = 0; it < 1500; it++) begin
      logic [1:0] d;
      d = 2'($urandom);
      sw_write(d);
      rm_model = d;
      chk("R5 random write", {62'h0, remap_o}, {62'h0, rm_model});
      chk("R10 random block", {63'h0, ext_regs_blocked_o}, {63'h0, rm_model == 2'b10});
      for (int j = 0; j < 4; j++) begin
        dec_chk("R8 R6 R7 R10 random decode", pick_addr(), 1'b1, rm_model);
      end
      if ((it % 300) == 299) begin
        logic na, nb;
        na = 1'($urandom); nb = 1'($urandom);
        boot_a_i = na; boot_b_i = nb;
        standby_exit_i = 1'b1;
        tick();
        standby_exit_i = 1'b0;
        repeat (4) tick();
        rm_model = model_boot_remap(nb, na);
        chk("R4 random resample", {62'h0, remap_o}, {62'h0, rm_model});
        chk("R2 random resample mode", {62'h0, boot_mode_o}, {62'h0, nb, na});
      end
    end
    if (seed_v == 32'hFFFF_FFFF) $display("seed marker");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule